// File: doc/BRIEF.md
# First-Fault Vector Load Sequencer

This block loads a 128-bit vector from memory one element at a time, and only the elements selected by a per-byte predicate are loaded. It drives a simple request/response memory port that may flag a fault on any single access. When the first selected element faults, the block raises a real fault. When a later element faults, the fault is absorbed. The block then stops issuing accesses and records the shortfall in a first-fault register, which holds one bit per byte of the vector.

The first-fault register only loses bits during a run of loads, so software can issue several loads in a row and then read the register once to see how far the data is valid. A separate initialise command sets the register back to all ones. Destination bytes that were not loaded read as zero. A `done` pulse marks the end of each load.

Top module: `ff_vload_seq`

## Requirements
- R1: After reset, `done_o`, `fault_o` and `mem_req_o` are 0, `vec_o` is all zero and `ffr_o` is all ones.
- R2: `elem_size_i` encodes the element width as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. The vector holds 16 bytes divided by that width elements. Element i is active when predicate bit i*width is 1 (the bit of its lowest byte). Other predicate bits have no effect, and inactive elements cause no memory access.
- R3: Accesses go out in ascending element order, one at a time. Element i is read at `base_addr_i + i*width`, and `mem_size_o` carries the size code. A new request comes only after the previous response. A request is held for exactly one cycle.
- R4: For a loaded element, the low `width` bytes of `mem_rsp_data_i` go little-endian into vector bytes i*width upward. Every other vector byte is zero when the load ends.
- R5: A fault on the first active element sets `fault_o`, loads nothing, leaves `ffr_o` unchanged and issues no further access.
- R6: A fault on a later active element leaves `fault_o` at 0. It clears `ffr_o` bits from byte i*width upward and issues no further access. The lanes loaded before it keep their data.
- R7: `ffr_o` bits are only cleared by loads and stay cleared across loads. `ffr_init_i` sampled while idle sets every bit to one.
- R8: After `start_i` is accepted, an inactive element costs 1 cycle and an active one costs 1 + response latency cycles. A full scan adds 1 cycle. `done_o` is then high for exactly one cycle.
- R9: `start_i` and `ffr_init_i` are ignored while a load is in progress, including the `done_o` cycle.
- R10: `fault_o` clears when a load is accepted and otherwise holds its value until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (accepted only when idle) |
| ffr_init_i | input | 1 | Set all first-fault bits to one (only when idle) |
| base_addr_i | input | 32 | Address of element 0 |
| elem_size_i | input | 2 | Element size code |
| pred_i | input | 16 | Per-byte predicate |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | 32 | Request address |
| mem_size_o | output | 2 | Request size code |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_data_i | input | 64 | Response data, little-endian |
| mem_rsp_fault_i | input | 1 | Response reports a fault |
| vec_o | output | 128 | Loaded vector |
| ffr_o | output | 16 | First-fault register |
| fault_o | output | 1 | Real fault from the first active element |
| done_o | output | 1 | Load finished, one-cycle pulse |

## Verification
A wrong element index or a stale "first active" flag shows up at the memory port in the very next request. It gives a wrong address, a missing request or a spurious request, so the bench compares the request lines against a model every cycle. A misclassified fault shows up in the `done_o` cycle as a wrong `fault_o` or a wrong cut point in `ffr_o`. An accidental first-fault write during a busy load shows up on `ffr_o` one cycle later, because the register is compared every cycle. Corrupted lane steering is only seen when the vector is compared after `done_o`.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} seq_state_t;

  localparam int unsigned RSP_W = 64;

  function automatic int unsigned elem_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction

  function automatic int unsigned elem_count(input int unsigned vbytes, input logic [1:0] sz);
    return vbytes >> sz;
  endfunction

  function automatic int unsigned byte_offset(input int unsigned idx, input logic [1:0] sz);
    return idx << sz;
  endfunction
endpackage

// File: rtl/ffvl_ctrl.sv
module ffvl_ctrl
  import ffvl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned IDX_W    = $clog2(VEC_BYTES) + 1,
  localparam int unsigned OFF_W    = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           size_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [VEC_BYTES-1:0] pred_i,
  input  logic                 rsp_valid_i,
  input  logic                 rsp_fault_i,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [1:0]           size_q_o,
  output logic [OFF_W-1:0]     boff_o,
  output logic                 busy_o,
  output logic                 load_go_o,
  output logic                 lane_wr_o,
  output logic                 sup_fault_o,
  output logic                 arch_fault_o,
  output logic                 fault_o,
  output logic                 done_o
);
  seq_state_t           state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [1:0]           size_q;
  logic [ADDR_W-1:0]    base_q;
  logic [VEC_BYTES-1:0] pred_q;
  logic                 first_q;
  logic                 fault_q;

  logic [IDX_W-1:0]     nelem;
  logic [OFF_W-1:0]     boff;
  logic                 in_range;
  logic                 elem_on;
  logic                 rsp_take;

  always_comb begin
    nelem     = IDX_W'(elem_count(VEC_BYTES, size_q));
    boff      = OFF_W'(byte_offset(32'(idx_q), size_q));
    in_range  = idx_q < nelem;
    elem_on   = in_range && pred_q[boff];
    rsp_take  = (state_q == ST_WAIT) && rsp_valid_i;
  end

  assign mem_req_o    = (state_q == ST_ISSUE) && elem_on;
  assign mem_addr_o   = base_q + ADDR_W'(boff);
  assign size_q_o     = size_q;
  assign boff_o       = boff;
  assign busy_o       = state_q != ST_IDLE;
  assign load_go_o    = (state_q == ST_IDLE) && start_i;
  assign lane_wr_o    = rsp_take && !rsp_fault_i;
  assign arch_fault_o = rsp_take && rsp_fault_i && first_q;
  assign sup_fault_o  = rsp_take && rsp_fault_i && !first_q;
  assign fault_o      = fault_q;
  assign done_o       = state_q == ST_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      size_q  <= '0;
      base_q  <= '0;
      pred_q  <= '0;
      first_q <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            size_q  <= size_i;
            base_q  <= base_i;
            pred_q  <= pred_i;
            idx_q   <= '0;
            first_q <= 1'b1;
            fault_q <= 1'b0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!in_range)    state_q <= ST_DONE;
          else if (elem_on) state_q <= ST_WAIT;
          else              idx_q   <= idx_q + IDX_W'(1);
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_fault_i) begin
              fault_q <= first_q;
              state_q <= ST_DONE;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              first_q <= 1'b0;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ffvl_lanes.sv
module ffvl_lanes
  import ffvl_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned OFF_W    = $clog2(VEC_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [OFF_W-1:0]       boff_i,
  input  logic [1:0]             size_i,
  input  logic [RSP_W-1:0]       data_i,
  output logic [VEC_BYTES*8-1:0] vec_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    logic [7:0] lane_q;
    logic       hit;
    logic [2:0] rel;

    always_comb begin
      rel = 3'(b - int'(boff_i));
      hit = wr_i && (b >= int'(boff_i)) &&
            (b < int'(boff_i) + int'(elem_bytes(size_i)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lane_q <= '0;
      else if (clr_i) lane_q <= '0;
      else if (hit)   lane_q <= data_i[8*rel +: 8];
    end

    assign vec_o[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/ffvl_ffr.sv
module ffvl_ffr #(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned OFF_W    = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic                 cut_i,
  input  logic [OFF_W-1:0]     cut_off_i,
  output logic [VEC_BYTES-1:0] ffr_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bit_q <= 1'b1;
      else if (init_i)  bit_q <= 1'b1;
      else if (cut_i && (b >= int'(cut_off_i))) bit_q <= 1'b0;
    end
    assign ffr_o[b] = bit_q;
  end
endmodule

// File: rtl/ff_vload_seq.sv
module ff_vload_seq
  import ffvl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VEC_BYTES = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   ffr_init_i,
  input  logic [ADDR_W-1:0]      base_addr_i,
  input  logic [1:0]             elem_size_i,
  input  logic [VEC_BYTES-1:0]   pred_i,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [1:0]             mem_size_o,
  input  logic                   mem_rsp_valid_i,
  input  logic [RSP_W-1:0]       mem_rsp_data_i,
  input  logic                   mem_rsp_fault_i,
  output logic [VEC_BYTES*8-1:0] vec_o,
  output logic [VEC_BYTES-1:0]   ffr_o,
  output logic                   fault_o,
  output logic                   done_o
);
  localparam int unsigned OFF_W = $clog2(VEC_BYTES);

  logic             busy;
  logic             load_go;
  logic             lane_wr;
  logic             sup_fault;
  logic             arch_fault;
  logic             ffr_init_ev;
  logic [OFF_W-1:0] boff;
  logic [1:0]       size_q;

  ffvl_ctrl #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .size_i       (elem_size_i),
    .base_i       (base_addr_i),
    .pred_i       (pred_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_fault_i  (mem_rsp_fault_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .size_q_o     (size_q),
    .boff_o       (boff),
    .busy_o       (busy),
    .load_go_o    (load_go),
    .lane_wr_o    (lane_wr),
    .sup_fault_o  (sup_fault),
    .arch_fault_o (arch_fault),
    .fault_o      (fault_o),
    .done_o       (done_o)
  );

  assign mem_size_o  = size_q;
  assign ffr_init_ev = ffr_init_i && !busy;

  ffvl_lanes #(.VEC_BYTES(VEC_BYTES)) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_go),
    .wr_i   (lane_wr),
    .boff_i (boff),
    .size_i (size_q),
    .data_i (mem_rsp_data_i),
    .vec_o  (vec_o)
  );

  ffvl_ffr #(.VEC_BYTES(VEC_BYTES)) u_ffr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (ffr_init_ev),
    .cut_i     (sup_fault),
    .cut_off_i (boff),
    .ffr_o     (ffr_o)
  );
endmodule

// File: rtl/ff_vload_seq_chk.sv
module ff_vload_seq_chk #(
  parameter int unsigned VEC_BYTES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mem_req,
  input logic                 done,
  input logic                 fault,
  input logic [VEC_BYTES-1:0] ffr,
  input logic                 ffr_init_ev,
  input logic                 sup_fault,
  input logic                 arch_fault
);
  assert_one_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req |=> !mem_req);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  assert_suppressed_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_fault |=> (!fault && done));

  assert_first_fault_raised_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arch_fault |=> (fault && done));

  assert_stop_after_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_fault || arch_fault) |=> !mem_req);

  assert_ffr_only_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ffr_init_ev |=> ((ffr & ~$past(ffr)) == '0));

  assert_req_not_in_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !mem_req);
endmodule

bind ff_vload_seq ff_vload_seq_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req     (mem_req_o),
  .done        (done_o),
  .fault       (fault_o),
  .ffr         (ffr_o),
  .ffr_init_ev (ffr_init_ev),
  .sup_fault   (sup_fault),
  .arch_fault  (arch_fault)
);

// File: tb/ff_vload_seq_tb.sv
module ff_vload_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         start, ffr_init;
  logic [31:0]  base;
  logic [1:0]   esize;
  logic [15:0]  pred;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic [1:0]   mem_size;
  logic         rsp_valid, rsp_fault;
  logic [63:0]  rsp_data;
  logic [127:0] vec;
  logic [15:0]  ffr;
  logic         fault, done;

  ff_vload_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ffr_init_i(ffr_init),
    .base_addr_i(base), .elem_size_i(esize), .pred_i(pred),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .mem_rsp_fault_i(rsp_fault),
    .vec_o(vec), .ffr_o(ffr), .fault_o(fault), .done_o(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [15:0] ffr_m;
  bit          fault_m;

  bit          exp_req [0:255];
  logic [31:0] exp_addr[0:255];
  bit          rsp_at  [0:255];
  bit          rsp_flt [0:255];
  logic [63:0] rsp_dat [0:255];

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd29 + 32'd7;
    return t[7:0] ^ a[15:8];
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // One load: model computed first, then a cycle-by-cycle comparison.
  task automatic run_load(input logic [31:0] b, input logic [1:0] sz,
                          input logic [15:0] p, input logic [15:0] flt,
                          input bit do_init, input int lat, input int poke,
                          input string tag);
    int nel, esz, c, done_cyc, cyc;
    bit first, stop;
    logic [15:0]  ffr_before;
    logic [127:0] vec_m;
    for (int i = 0; i < 256; i++) begin
      exp_req[i] = 0; exp_addr[i] = '0; rsp_at[i] = 0; rsp_flt[i] = 0; rsp_dat[i] = '0;
    end
    if (do_init) ffr_m = '1;          // R7 initialise while idle
    ffr_before = ffr_m;
    fault_m = 0;
    vec_m = '0;
    nel = 16 >> sz;
    esz = 1 << sz;
    c = 1; first = 1; stop = 0;
    for (int i = 0; i < nel && !stop; i++) begin
      int off;
      off = i * esz;
      if (!p[off]) begin
        c++;                           // R2 inactive: no access, one cycle
      end else begin
        exp_req[c]  = 1;
        exp_addr[c] = b + 32'(off);
        rsp_at[c + lat]  = 1;
        rsp_flt[c + lat] = flt[i];
        for (int j = 0; j < 8; j++) rsp_dat[c + lat][8*j +: 8] = mb(b + 32'(off + j));
        c += 1 + lat;
        if (flt[i]) begin
          if (first) fault_m = 1;                      // R5
          else ffr_m &= (16'h1 << off) - 16'h1;        // R6
          stop = 1;
        end else begin
          for (int j = 0; j < esz; j++) vec_m[8*(off + j) +: 8] = mb(b + 32'(off + j));
          first = 0;
        end
      end
    end
    if (!stop) c++;
    done_cyc = c;

    @(negedge clk);
    start = 1; ffr_init = do_init; base = b; esize = sz; pred = p;
    @(posedge clk);
    @(negedge clk);
    start = 0; ffr_init = 0;
    cyc = 1;
    while (cyc <= done_cyc + 1) begin
      rsp_valid = rsp_at[cyc];
      rsp_fault = rsp_at[cyc] ? rsp_flt[cyc] : 1'b0;
      rsp_data  = rsp_dat[cyc];
      start     = (cyc == poke);       // R9 poke while busy
      ffr_init  = (cyc == poke);
      base      = 32'hDEAD_0000;
      #1;
      chk(mem_req == exp_req[cyc], {tag, " R3 mem_req"}, 128'(mem_req), 128'(exp_req[cyc]));
      if (exp_req[cyc]) begin
        chk(mem_addr == exp_addr[cyc], {tag, " R3 addr"}, 128'(mem_addr), 128'(exp_addr[cyc]));
        chk(mem_size == sz, {tag, " R3 size"}, 128'(mem_size), 128'(sz));
      end
      chk(done == (cyc == done_cyc), {tag, " R8 done"}, 128'(done), 128'(cyc == done_cyc));
      chk(fault == ((cyc < done_cyc) ? 1'b0 : fault_m), {tag, " R10 fault"},
          128'(fault), 128'((cyc < done_cyc) ? 1'b0 : fault_m));
      chk(ffr == ((cyc < done_cyc) ? ffr_before : ffr_m), {tag, " R7 R9 ffr"},
          128'(ffr), 128'((cyc < done_cyc) ? ffr_before : ffr_m));
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    rsp_valid = 0; rsp_fault = 0; rsp_data = '0; start = 0; ffr_init = 0;
    #1;
    chk(vec == vec_m, {tag, " R4 vec"}, vec, vec_m);
    chk(ffr == ffr_m, {tag, " R5 R6 ffr end"}, 128'(ffr), 128'(ffr_m));
    chk(fault == fault_m, {tag, " R5 R6 fault end"}, 128'(fault), 128'(fault_m));
  endtask

  initial begin
    rst_n = 0; start = 0; ffr_init = 0; base = '0; esize = '0; pred = '0;
    rsp_valid = 0; rsp_fault = 0; rsp_data = '0;
    ffr_m = '1; fault_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(done == 0,    "R1 done",    128'(done),    128'(0));
    chk(fault == 0,   "R1 fault",   128'(fault),   128'(0));
    chk(mem_req == 0, "R1 mem_req", 128'(mem_req), 128'(0));
    chk(ffr == '1,    "R1 ffr",     128'(ffr),     128'(16'hFFFF));
    chk(vec == '0,    "R1 vec",     vec,           128'(0));

    // bytes, all active, no faults
    run_load(32'h0000_0100, 2'd0, 16'hFFFF, 16'h0000, 0, 1, 5, "T1 R2");
    // words, element 3 inactive, element 2 faults late -> suppressed (R6)
    run_load(32'h0000_2000, 2'd2, 16'h0111, 16'h0004, 0, 2, 0, "T2 R6");
    // halves, no faults; init poked while busy must be ignored (R9, R7 cumulative)
    run_load(32'h0000_0031, 2'd1, 16'h5555, 16'h0000, 0, 3, 4, "T3 R9");
    // doublewords, first active element (1) faults -> real fault (R5)
    run_load(32'h0000_0400, 2'd3, 16'hFF00, 16'h0002, 0, 2, 3, "T4 R5");
    // initialise, empty predicate: no access at all, fault cleared (R10)
    run_load(32'h0000_0800, 2'd0, 16'h0000, 16'hFFFF, 1, 1, 7, "T5 R2 R10");
    // halves: bit 7 is not a lowest byte so element 3 stays inactive (R2); element 5 faults late
    run_load(32'h0001_0000, 2'd1, 16'h0484, 16'h0020, 0, 1, 2, "T6 R2 R6");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule